// File: doc/BRIEF.md
# Relative Branch Decision Unit

This unit resolves a relative branch for an 8-bit processor core. It takes a 4-bit condition selector, the N, Z, V and C flags, the address of the following instruction and an 8-bit two's-complement displacement. One clock later it reports whether the branch is taken and gives the 16-bit destination address. The destination is formed whether or not the branch is taken, so fetch logic can use it without waiting.

A separate call input marks a branch-to-subroutine. A call is always taken and raises a request to push the return address, which is the address of the following instruction. The unit only reads the flags and never changes them. Stack writes and instruction fetch are left to the surrounding logic.

Top module: `br_resolve`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, valid_o, taken_o, push_o, target_o and ret_addr_o are all 0.
- R2: The outputs are registered. Inputs sampled at one rising clock edge appear at that edge. valid_o copies valid_i. When valid_o is 0, taken_o and push_o are 0.
- R3: Selector 4'h0 is always taken. Selector 4'h1 is never taken.
- R4: Single-flag selectors: 4'h4 is taken when C=0 and 4'h5 when C=1. 4'h6 is taken when Z=0 and 4'h7 when Z=1. 4'h8 is taken when V=0 and 4'h9 when V=1. 4'hA is taken when N=0 and 4'hB when N=1.
- R5: Signed selectors: 4'hC (greater-or-equal) is taken when N^V=0. 4'hD (less-than) is taken when N^V=1. 4'hE (greater-than) is taken when Z|(N^V)=0. 4'hF (less-or-equal) is taken when Z|(N^V)=1.
- R6: Unsigned selectors: 4'h2 (higher) is taken when C|Z=0. 4'h3 (lower-or-same) is taken when C|Z=1.
- R7: When valid_o is 1, target_o equals next_pc_i plus the sign-extended disp_i, modulo 2^16. This holds whether or not the branch is taken.
- R8: When call_i is 1, the branch is taken whatever cond_i and the flags are. push_o is 1 and ret_addr_o equals next_pc_i.
- R9: For a non-call branch, push_o and ret_addr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A branch is presented on this cycle |
| cond_i | input | 4 | Condition selector |
| call_i | input | 1 | The branch is a subroutine call |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| next_pc_i | input | 16 | Address of the following instruction |
| disp_i | input | 8 | Signed displacement |
| valid_o | output | 1 | The result is valid |
| taken_o | output | 1 | The branch is taken |
| target_o | output | 16 | Destination address |
| push_o | output | 1 | Request to push the return address |
| ret_addr_o | output | 16 | Return address for the push |

## Verification
Every selector is run against all sixteen flag combinations. These runs catch a swapped pair of selectors, a signed compare built from N alone instead of N^V, and a greater-than or lower-or-same that drops the Z term. Displacements of 8'h80 and 8'h7F across the 16'h0000 and 16'hFFFF boundaries catch an adder that zero-extends the displacement or does not wrap. Calls made with the never selector and with a failing condition catch a design that lets the condition veto a call. Presenting a valid call and then idle cycles catches a design that holds push_o or taken_o high after the request has gone.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;
  typedef enum logic [3:0] {
    SEL_ALWAYS = 4'h0, SEL_NEVER = 4'h1, SEL_HI = 4'h2, SEL_LS = 4'h3,
    SEL_CC     = 4'h4, SEL_CS    = 4'h5, SEL_NE = 4'h6, SEL_EQ = 4'h7,
    SEL_VC     = 4'h8, SEL_VS    = 4'h9, SEL_PL = 4'hA, SEL_MI = 4'hB,
    SEL_GE     = 4'hC, SEL_LT    = 4'hD, SEL_GT = 4'hE, SEL_LE = 4'hF
  } br_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } br_flags_t;
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_resolve_pkg::*;
(
  input  logic [3:0] cond_i,
  input  br_flags_t  flags_i,
  output logic       hit_o
);
  localparam int NPAIR = 8;

  // Even selector of each pair is the "true" sense; odd one inverts it.
  logic [NPAIR-1:0] base;
  logic             nxv;

  assign nxv = flags_i.n ^ flags_i.v;

  always_comb begin
    base[0] = 1'b1;
    base[1] = ~(flags_i.c | flags_i.z);
    base[2] = ~flags_i.c;
    base[3] = ~flags_i.z;
    base[4] = ~flags_i.v;
    base[5] = ~flags_i.n;
    base[6] = ~nxv;
    base[7] = ~(flags_i.z | nxv);
  end

  assign hit_o = base[cond_i[3:1]] ^ cond_i[0];
endmodule

// File: rtl/br_target_add.sv
module br_target_add #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
  endgenerate

  assign target_o = base_i + disp_ext;
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_resolve_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        cond_i,
  input  logic              call_i,
  input  logic              flag_n_i,
  input  logic              flag_z_i,
  input  logic              flag_v_i,
  input  logic              flag_c_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] ret_addr_o
);
  br_flags_t         flags;
  logic              cond_hit;
  logic [ADDR_W-1:0] target_d;

  assign flags = '{n: flag_n_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};

  br_cond_eval u_cond (
    .cond_i (cond_i),
    .flags_i(flags),
    .hit_o  (cond_hit)
  );

  br_target_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_add (
    .base_i  (next_pc_i),
    .disp_i  (disp_i),
    .target_o(target_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      target_o   <= '0;
      push_o     <= 1'b0;
      ret_addr_o <= '0;
    end else begin
      valid_o    <= valid_i;
      taken_o    <= valid_i & (call_i | cond_hit);
      target_o   <= valid_i ? target_d : '0;
      push_o     <= valid_i & call_i;
      ret_addr_o <= (valid_i & call_i) ? next_pc_i : '0;
    end
  end

  // Assertions
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!taken_o && !push_o));

  a_r8_push_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> taken_o);

  a_r8_call_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && push_o) |-> ret_addr_o == $past(next_pc_i));

  a_r9_no_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && !$past(call_i)) |-> (!push_o && ret_addr_o == '0));

  a_r7_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o) |-> target_o ==
      ADDR_W'($past(next_pc_i) + ADDR_W'($signed($past(disp_i)))));

  a_r3_never: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && !$past(call_i) && $past(cond_i) == 4'h1) |-> !taken_o);

  a_r4_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && $past(valid_i) && !$past(call_i) && $past(cond_i) == 4'h7)
      |-> taken_o == $past(flag_z_i));
endmodule

// File: tb/br_resolve_test.sv
`timescale 1ns/1ps
module br_resolve_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  cond_i = '0;
  logic        call_i = 1'b0;
  logic        n_i = 1'b0, z_i = 1'b0, v_i = 1'b0, c_i = 1'b0;
  logic [15:0] pc_i = '0;
  logic [7:0]  disp_i = '0;
  logic        valid_o, taken_o, push_o;
  logic [15:0] target_o, ret_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  br_resolve uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .cond_i(cond_i),
    .call_i(call_i), .flag_n_i(n_i), .flag_z_i(z_i), .flag_v_i(v_i),
    .flag_c_i(c_i), .next_pc_i(pc_i), .disp_i(disp_i),
    .valid_o(valid_o), .taken_o(taken_o), .target_o(target_o),
    .push_o(push_o), .ret_addr_o(ret_o)
  );

  function automatic bit ref_taken(input logic [3:0] s, input bit n, z, v, c);
    case (s)
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return !(c || z);
      4'h3: return c || z;
      4'h4: return !c;
      4'h5: return c;
      4'h6: return !z;
      4'h7: return z;
      4'h8: return !v;
      4'h9: return v;
      4'hA: return !n;
      4'hB: return n;
      4'hC: return n == v;
      4'hD: return n != v;
      4'hE: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, result registered on next posedge, sample at following negedge
  task automatic apply(input string req, input bit vld, input logic [3:0] s, input bit call,
                       input logic [3:0] f, input logic [15:0] pc, input logic [7:0] d);
    bit tk;
    logic [15:0] tgt;
    valid_i = vld; cond_i = s; call_i = call;
    {n_i, z_i, v_i, c_i} = f; pc_i = pc; disp_i = d;
    @(negedge clk);
    tk  = vld && (call || ref_taken(s, f[3], f[2], f[1], f[0]));
    tgt = vld ? 16'(pc + {{8{d[7]}}, d}) : 16'h0;
    check(req, "valid", {15'h0, valid_o}, {15'h0, vld});
    check(req, "taken", {15'h0, taken_o}, {15'h0, tk});
    check(req, "push", {15'h0, push_o}, {15'h0, vld && call});
    check("R7", "target", target_o, tgt);
    check(call ? "R8" : "R9", "ret_addr", ret_o, (vld && call) ? pc : 16'h0);
  endtask

  task automatic t_reset;
    check("R1", "valid", {15'h0, valid_o}, 16'h0);
    check("R1", "taken", {15'h0, taken_o}, 16'h0);
    check("R1", "push", {15'h0, push_o}, 16'h0);
    check("R1", "target", target_o, 16'h0);
    check("R1", "ret_addr", ret_o, 16'h0);
  endtask

  task automatic t_sweep(input string req, input logic [3:0] lo, input logic [3:0] hi);
    for (int s = int'(lo); s <= int'(hi); s++)
      for (int f = 0; f < 16; f++)
        apply(req, 1'b1, 4'(s), 1'b0, 4'(f), 16'h1000 + 16'(f), 8'(s * 3));
  endtask

  task automatic t_target;
    apply("R7", 1'b1, 4'h1, 1'b0, 4'h0, 16'h0000, 8'h80);
    apply("R7", 1'b1, 4'h0, 1'b0, 4'h0, 16'hFFFF, 8'h7F);
    apply("R7", 1'b1, 4'h0, 1'b0, 4'h0, 16'h0005, 8'hFB);
    apply("R7", 1'b1, 4'h7, 1'b0, 4'h0, 16'hFFF0, 8'h10);
    apply("R7", 1'b1, 4'h0, 1'b0, 4'h0, 16'h8000, 8'hFF);
  endtask

  task automatic t_call;
    apply("R8", 1'b1, 4'h1, 1'b1, 4'h0, 16'h2345, 8'h10);
    apply("R8", 1'b1, 4'h7, 1'b1, 4'h0, 16'hFFFE, 8'h04);
    apply("R8", 1'b1, 4'hD, 1'b1, 4'b1010, 16'h0100, 8'hF0);
    apply("R9", 1'b1, 4'h0, 1'b0, 4'h0, 16'h2345, 8'h10);
  endtask

  task automatic t_idle;
    apply("R8", 1'b1, 4'h0, 1'b1, 4'h0, 16'h4000, 8'h02);
    apply("R2", 1'b0, 4'h0, 1'b1, 4'hF, 16'h4444, 8'h22);
    apply("R2", 1'b0, 4'h3, 1'b0, 4'h4, 16'h1234, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sweep("R3", 4'h0, 4'h1);
    t_sweep("R6", 4'h2, 4'h3);
    t_sweep("R4", 4'h4, 4'hB);
    t_sweep("R5", 4'hC, 4'hF);
    t_target();
    t_call();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule